// File: doc/BRIEF.md
# Port Edge-Event Pending Register

This block records edge events on the four low pins of an I/O port and raises an interrupt request while any of them is pending. Each pin has its own enable and its own polarity select (rising or falling). Each pin input goes through a two-stage synchronizer, and an edge detector then compares the synchronized level with the level from the previous cycle.

The pending flags have no address of their own. Software reaches them only through an exchange strobe issued while the mode input holds the access code 09h. In that cycle the old flags are driven onto the W output, and the W input value is loaded into the flags at the clock edge. Exchanging with 00h therefore reads and clears all flags in one step. If an edge arrives in the same cycle as an exchange, its flag is set anyway, so no event is lost.

Top module: `wkp_pending_top`

## Requirements
- R1: After the asynchronous reset, all pending flags are 0, `irq_o` is 0 and `w_o` is 00h.
- R2: An exchange happens only when `xchg_i` is 1 and `mode_i` equals 09h. With any other mode value, `w_o` stays 00h and the flags keep their values.
- R3: During an exchange cycle, `w_o[3:0]` shows the flags as they were before that cycle (bit n is pin n). At the clock edge that ends the cycle, the flags take the value of `w_i[3:0]`.
- R4: An exchange with `w_i` = 0 clears every flag that is not hit by a new edge in the same cycle.
- R5: `w_o[7:4]` always reads 0.
- R6: With `edge_sel_i[n]`=0 and `pin_en_i[n]`=1, a rising level change on `pins_i[n]` sets flag n. The flag is set at the third rising clock edge after the pin changes.
- R7: With `edge_sel_i[n]`=1 and `pin_en_i[n]`=1, a falling level change on `pins_i[n]` sets flag n. A level change in the opposite direction to the one selected never sets the flag.
- R8: While `pin_en_i[n]` is 0, flag n is never set by an edge.
- R9: When an enabled edge and an exchange land on the same clock edge, the flag for that pin ends up set, whatever value `w_i` carries.
- R10: `irq_o` is 1 exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 4 | Asynchronous pin levels |
| edge_sel_i | input | 4 | Per-pin polarity: 0 rising, 1 falling |
| pin_en_i | input | 4 | Per-pin event enable |
| mode_i | input | 8 | Mode register value; 09h selects access |
| xchg_i | input | 1 | Exchange strobe |
| w_i | input | 4 | Value to load into the flags |
| w_o | output | 8 | Previous flag values during an exchange, else 00h |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
Every pin is exercised in every combination of polarity select, enable and transition direction. This separates a correct match from a wrong polarity, from a missing enable gate, and from crosstalk to a neighbouring pin. All 16 nibble values are exchanged in sequence. Each exchange must return the value loaded by the one before it, which exposes bit swaps and stuck bits on both the load path and the return path. All 256 mode values are tried while flags hold a known pattern, and only 09h may disturb that pattern. Edges timed to land on the same clock edge as an exchange with 00h show whether the edge takes priority over the write.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int unsigned EDGE_PINS = 4;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned MODE_W    = 8;
  localparam int unsigned SYNC_STG  = 2;
  localparam logic [MODE_W-1:0] XCHG_CODE = 8'h09;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wkp_edge_det.sv
module wkp_edge_det
  import wkp_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < N; p++) begin : g_pin
    edge_pol_e pol;
    logic      rise, fall;
    assign pol      = edge_pol_e'(pol_i[p]);
    assign rise     = lvl_i[p] & ~prev_q[p];
    assign fall     = ~lvl_i[p] & prev_q[p];
    assign hit_o[p] = en_i[p] & ((pol == EDGE_FALL) ? fall : rise);
  end
endmodule

// File: rtl/wkp_pend_reg.sv
module wkp_pend_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         acc_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  // edges are OR-ed after the write so they win
  always_comb begin
    pend_d = acc_i ? wdata_i : pend_q;
    pend_d = pend_d | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/wkp_pending_top.sv
module wkp_pending_top
  import wkp_pkg::*;
#(
  parameter int unsigned          N      = EDGE_PINS,
  parameter int unsigned          DW     = DATA_W,
  parameter int unsigned          MW     = MODE_W,
  parameter int unsigned          STAGES = SYNC_STG,
  parameter logic [MODE_W-1:0]    CODE   = XCHG_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pins_i,
  input  logic [N-1:0]  edge_sel_i,
  input  logic [N-1:0]  pin_en_i,
  input  logic [MW-1:0] mode_i,
  input  logic          xchg_i,
  input  logic [N-1:0]  w_i,
  output logic [DW-1:0] w_o,
  output logic          irq_o
);
  localparam int unsigned PAD_W = DW - N;

  logic [N-1:0] lvl, hit, pend_q;
  logic         acc;

  wkp_sync #(.WIDTH(N), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl)
  );

  wkp_edge_det #(.N(N)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .pol_i (edge_sel_i),
    .en_i  (pin_en_i),
    .hit_o (hit)
  );

  assign acc = xchg_i && (mode_i == CODE[MW-1:0]);

  wkp_pend_reg #(.N(N)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .wdata_i(w_i),
    .hit_i  (hit),
    .pend_o (pend_q)
  );

  assign w_o   = acc ? {{PAD_W{1'b0}}, pend_q} : '0;
  assign irq_o = |pend_q;
endmodule

// File: rtl/wkp_pending_chk.sv
module wkp_pending_chk #(
  parameter int unsigned       N    = 4,
  parameter int unsigned       DW   = 8,
  parameter int unsigned       MW   = 8,
  parameter logic [MW-1:0]     CODE = 8'h09
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  pin_en_i,
  input logic [MW-1:0] mode_i,
  input logic          xchg_i,
  input logic [N-1:0]  w_i,
  input logic [DW-1:0] w_o,
  input logic          irq_o,
  input logic [N-1:0]  hit,
  input logic [N-1:0]  pend_q
);
  logic sel;
  assign sel = xchg_i && (mode_i == CODE);

  // R5
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_o[DW-1:N] == '0);

  // R2
  a_r2_quiet_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> w_o == '0);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && hit == '0) |=> $stable(pend_q));

  // R3
  a_r3_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |-> w_o[N-1:0] == pend_q);

  // R4
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && w_i == '0) |=> (pend_q & ~$past(hit)) == '0);

  // R8
  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & ~pin_en_i) == '0);

  // R9
  a_r9_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && hit != '0) |=> (pend_q & $past(hit)) == $past(hit));

  // R10
  a_r10_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(hit) != '0 || $past(sel)));
endmodule

bind wkp_pending_top wkp_pending_chk #(.N(N), .DW(DW), .MW(MW), .CODE(CODE[MW-1:0])) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pin_en_i(pin_en_i),
  .mode_i  (mode_i),
  .xchg_i  (xchg_i),
  .w_i     (w_i),
  .w_o     (w_o),
  .irq_o   (irq_o),
  .hit     (hit),
  .pend_q  (pend_q)
);

// File: tb/wkp_pending_tb.sv
module wkp_pending_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pins_i = '0;
  logic [3:0] edge_sel_i = '0;
  logic [3:0] pin_en_i = '0;
  logic [7:0] mode_i = '0;
  logic       xchg_i = 1'b0;
  logic [3:0] w_i = '0;
  logic [7:0] w_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wkp_pending_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .edge_sel_i(edge_sel_i),
    .pin_en_i(pin_en_i), .mode_i(mode_i), .xchg_i(xchg_i), .w_i(w_i),
    .w_o(w_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(posedge clk_i);
    #1;
  endtask

  // drive an exchange for one cycle, sample w_o mid-cycle
  task automatic xchg(input logic [7:0] m, input logic [3:0] v, output logic [7:0] r);
    @(negedge clk_i);
    mode_i = m; w_i = v; xchg_i = 1'b1;
    #1 r = w_o;
    @(posedge clk_i);
    #1 xchg_i = 1'b0; w_i = '0; mode_i = '0;
  endtask

  initial begin
    logic [7:0] r;
    logic [3:0] prev;
    cycles(2);
    // R1
    check("R1 w_o", w_o, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    cycles(2);
    xchg(8'h09, 4'h0, r);
    check("R1 flags", r, 8'h00);

    // R6 R7 R8: full sweep of pin, polarity, enable, direction
    for (int p = 0; p < 4; p++)
      for (int sel = 0; sel < 2; sel++)
        for (int en = 0; en < 2; en++)
          for (int dir = 0; dir < 2; dir++) begin
            pin_en_i = '0;
            edge_sel_i = '0; edge_sel_i[p] = sel[0];
            pins_i = '0; pins_i[p] = dir[0];  // rest level: dir 0 -> low
            cycles(4);
            xchg(8'h09, 4'h0, r);
            pin_en_i[p] = en[0];
            @(negedge clk_i) pins_i[p] = ~dir[0];
            @(posedge clk_i); @(posedge clk_i); #1;
            check("R6 latency", {7'd0, irq_o}, 8'h00);
            @(posedge clk_i); #1;
            begin
              logic [7:0] e;
              e = (en == 1 && dir == sel) ? (8'h01 << p) : 8'h00;
              check("R10 irq", {7'd0, irq_o}, {7'd0, |e});
              xchg(8'h09, 4'h0, r);
              check(sel ? "R7 falling/R8" : "R6 rising/R8", r, e);
              check("R5 upper", {r[7:4], 4'h0}, 8'h00);
            end
            pin_en_i = '0; pins_i = '0;
            cycles(4);
          end

    // R3 R5: load/return sweep over all nibbles
    xchg(8'h09, 4'h0, r);
    prev = 4'h0;
    for (int v = 0; v < 17; v++) begin
      xchg(8'h09, v[3:0], r);
      check("R3 return", r, {4'h0, prev});
      prev = v[3:0];
      check("R10 irq after load", {7'd0, irq_o}, {7'd0, |prev});
    end

    // R2: every other mode leaves flags alone
    xchg(8'h09, 4'hA, r);
    for (int m = 0; m < 256; m++) begin
      if (m != 9) begin
        xchg(m[7:0], 4'h5, r);
        check("R2 no access out", r, 8'h00);
      end
    end
    xchg(8'h09, 4'h0, r);
    check("R2 flags kept", r, 8'h0A);
    @(negedge clk_i) xchg_i = 1'b1; mode_i = 8'h08; w_i = 4'hF;
    #1 check("R2 near code", w_o, 8'h00);
    @(posedge clk_i); #1 xchg_i = 1'b0;
    xchg(8'h09, 4'h0, r);
    check("R4 cleared", r, 8'h00);

    // R9 R4: edge landing on the same clock edge as a clear
    for (int p = 0; p < 4; p++) begin
      edge_sel_i = '0; pins_i = '0; pin_en_i = 4'hF;
      cycles(4);
      xchg(8'h09, 4'hF, r);
      @(negedge clk_i) pins_i[p] = 1'b1;
      @(posedge clk_i); @(posedge clk_i);
      xchg(8'h09, 4'h0, r);
      check("R9 old value", r, 8'h0F);
      xchg(8'h09, 4'h0, r);
      check("R9 edge wins/R4", r, 8'h01 << p);
      pin_en_i = '0; pins_i = '0;
      cycles(4);
    end
    xchg(8'h09, 4'h0, r);
    check("R4 empty", r, 8'h00);
    check("R10 idle", {7'd0, irq_o}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_CYC; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule